// File: doc/BRIEF.md
# Square-Wave Countdown Timer

This block is a 14-bit programmable down-counter whose single output line idles high. It is meant to drive a CPU trap input, for example so that a monitor can single-step a program. Software loads a count value and a 2-bit mode through a byte-wide register write port. A separate start command then arms the timer. Counting advances only on the timer-clock strobe `tick_i`. This strobe comes from a timer clock that is independent of the bus clock, so the strobe period sets the output pulse width.

Every mode counts an output period as two consecutive phases, a high phase and then a low phase. The square-wave modes split the count N into a high phase of ceil(N/2) ticks and a low phase of floor(N/2) ticks, so an odd count puts its extra tick in the high phase. A count of 197 gives 99 ticks high and 98 ticks low. The pulse modes keep the output high for N-1 ticks and then drive it low for one tick. The repeating modes reload at the end of every low phase. The one-shot modes stop and return the output high. A stop command halts the timer at any time.

Top module: `tmr_sqwave`

## Requirements
- R1: While reset is held and after it is released, `tmr_o` is high and the timer is stopped.
- R2: Address 2'b10 holds count bits [7:0]. Address 2'b11 holds count bits [13:8] in data[5:0] and the mode in data[7:6]. Writing these registers never starts the timer, and `tmr_o` stays high.
- R3: A write to address 2'b00 with data[7:6]=2'b11 is the start command. It restarts the timer from the beginning of a high phase, and this holds even if the timer is already running. After the start, `tmr_o` stays high for the full high phase and goes low in the cycle after the tick that ends that phase.
- R4: In the square-wave modes (mode[1]=0), the high phase lasts ceil(N/2) ticks and the low phase lasts floor(N/2) ticks. For N=197 this is 99 ticks high and 98 ticks low.
- R5: Mode 2'b01 repeats the period. At the end of each low phase the output returns high and a new high phase is loaded from the count register. A phase length is always taken from the count register value present when that phase is loaded.
- R6: Mode 2'b00 runs a single square-wave period, then stops with `tmr_o` high.
- R7: Mode 2'b10 keeps `tmr_o` high for N-1 ticks, drives it low for exactly one tick, then stops with it high.
- R8: Mode 2'b11 repeats the N-1 high / 1 low pattern indefinitely.
- R9: A write to address 2'b00 with data[7:6]=2'b01 is the stop command. It halts counting, and `tmr_o` is high in the next cycle and stays high under further ticks until the next start.
- R10: A count below 2 is treated as 2.
- R11: Cycles without `tick_i` do not advance the timer.
- R12: Writes to address 2'b01, and command writes with data[7:6] equal to 2'b00 or 2'b10, have no effect on the output sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | 8 | Write data |
| tick_i | input | 1 | Timer-clock strobe, one bus cycle per timer count |
| tmr_o | output | 1 | Timer output, idles high, low during the low phase |

## Verification
On every cycle, the assertions check the following:
- the square-wave split never puts more than one extra tick in the high phase;
- neither phase length is ever zero;
- a start always loads a fresh high phase;
- a stop always parks the output high;
- cycles without a tick freeze the counter;
- a one-shot period stops the timer at its end.

Only the bench scenarios can show the end-to-end tick counts of each phase over whole periods. These include the 99/98 split for 197, reload with a count rewritten mid-period, and pulse placement at terminal count. The scenarios also show that loading alone never starts the timer and that ignored writes leave a running sequence undisturbed.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_CMD    = 0;
  localparam int ADDR_SPARE  = 1;
  localparam int ADDR_CNT_LO = 2;
  localparam int ADDR_CNT_HI = 3;

  localparam logic [1:0] CMD_STOP  = 2'b01;
  localparam logic [1:0] CMD_START = 2'b11;

  // mode[0]: repeat, mode[1]: pulse shape
  typedef enum logic [1:0] {
    MODE_SQ_ONCE    = 2'b00,
    MODE_SQ_CONT    = 2'b01,
    MODE_PULSE_ONCE = 2'b10,
    MODE_PULSE_CONT = 2'b11
  } tmr_mode_e;

  localparam int MIN_COUNT = 2;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 14,
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [1:0]        mode_o,
  output logic              start_o,
  output logic              stop_o
);
  localparam int HI_W = CNT_W - DATA_W;

  logic [DATA_W-1:0] lo_q;
  logic [HI_W-1:0]   hi_q;
  logic [1:0]        mode_q;
  logic [1:0]        cmd_fld;
  logic              cmd_wr;

  assign cmd_fld = wr_data_i[DATA_W-1 -: 2];
  assign cmd_wr  = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_CMD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      hi_q   <= '0;
      mode_q <= MODE_SQ_ONCE;
    end else if (wr_en_i) begin
      if (wr_addr_i == ADDR_W'(ADDR_CNT_LO)) lo_q <= wr_data_i;
      if (wr_addr_i == ADDR_W'(ADDR_CNT_HI)) begin
        hi_q   <= wr_data_i[HI_W-1:0];
        mode_q <= cmd_fld;
      end
    end
  end

  assign count_o = {hi_q, lo_q};
  assign mode_o  = mode_q;
  assign start_o = cmd_wr && (cmd_fld == CMD_START);
  assign stop_o  = cmd_wr && (cmd_fld == CMD_STOP);

  // R12
  spare_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADDR_W'(ADDR_SPARE)) |=> $stable(count_o) && $stable(mode_o));
endmodule

// File: rtl/tmr_split.sv
module tmr_split
  import tmr_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  input  logic [1:0]       mode_i,
  output logic [CNT_W-1:0] hi_len_o,
  output logic [CNT_W-1:0] lo_len_o
);
  logic [CNT_W-1:0] n_eff;
  logic [CNT_W:0]   n_plus;

  always_comb begin
    n_eff  = (count_i < CNT_W'(MIN_COUNT)) ? CNT_W'(MIN_COUNT) : count_i;
    n_plus = {1'b0, n_eff} + (CNT_W+1)'(1);
    if (mode_i[1]) begin
      hi_len_o = n_eff - CNT_W'(1);
      lo_len_o = CNT_W'(1);
    end else begin
      // odd remainder goes to the high phase
      hi_len_o = n_plus[CNT_W:1];
      lo_len_o = n_eff >> 1;
    end
  end

  // R4
  sq_split_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i[1] |-> (hi_len_o >= lo_len_o) && ((hi_len_o - lo_len_o) <= CNT_W'(1)));
  // R10
  min_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_len_o != '0) && (lo_len_o != '0));
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             tick_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] hi_len_i,
  input  logic [CNT_W-1:0] lo_len_i,
  output logic [1:0]       run_mode_o,
  output logic             tmr_o
);
  logic             run_q;
  logic             low_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       mode_q;
  logic             last_tick;

  assign last_tick = tick_i && run_q && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      low_q  <= 1'b0;
      cnt_q  <= '0;
      mode_q <= MODE_SQ_ONCE;
    end else if (start_i) begin
      run_q  <= 1'b1;
      low_q  <= 1'b0;
      cnt_q  <= hi_len_i;
      mode_q <= mode_i;
    end else if (stop_i) begin
      run_q <= 1'b0;
      low_q <= 1'b0;
    end else if (last_tick) begin
      if (!low_q) begin
        low_q <= 1'b1;
        cnt_q <= lo_len_i;
      end else if (mode_q[0]) begin
        low_q <= 1'b0;
        cnt_q <= hi_len_i;
      end else begin
        run_q <= 1'b0;
        low_q <= 1'b0;
      end
    end else if (tick_i && run_q) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign run_mode_o = mode_q;
  assign tmr_o      = !(run_q && low_q);

  // R3
  start_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> run_q && !low_q && tmr_o);
  // R9
  stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> !run_q && tmr_o);
  // R11
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !stop_i && !tick_i) |=> $stable(cnt_q) && $stable(low_q) && $stable(run_q));
  // R6
  single_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !stop_i && last_tick && low_q && !mode_q[0]) |=> !run_q && tmr_o);
  // R10
  cnt_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> cnt_q != '0);
endmodule

// File: rtl/tmr_sqwave.sv
module tmr_sqwave
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 14,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              tick_i,
  output logic              tmr_o
);
  logic [CNT_W-1:0] count;
  logic [1:0]       reg_mode;
  logic [1:0]       run_mode;
  logic [1:0]       split_mode;
  logic             start;
  logic             stop;
  logic [CNT_W-1:0] hi_len;
  logic [CNT_W-1:0] lo_len;

  tmr_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .count_o(count), .mode_o(reg_mode), .start_o(start), .stop_o(stop)
  );

  // a start takes the register mode, otherwise the latched run mode
  assign split_mode = start ? reg_mode : run_mode;

  tmr_split #(.CNT_W(CNT_W)) u_split (
    .clk_i, .rst_ni, .count_i(count), .mode_i(split_mode),
    .hi_len_o(hi_len), .lo_len_o(lo_len)
  );

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni, .start_i(start), .stop_i(stop), .tick_i,
    .mode_i(reg_mode), .hi_len_i(hi_len), .lo_len_i(lo_len),
    .run_mode_o(run_mode), .tmr_o
  );
endmodule

// File: tb/tmr_sqwave_bench.sv
`timescale 1ns/1ps
module tmr_sqwave_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       tick = 1'b0;
  logic       tmr;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_sqwave u_tmr_sqwave (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .tick_i(tick), .tmr_o(tmr)
  );

  function automatic int eff(int n);
    return (n < 2) ? 2 : n;
  endfunction
  function automatic int hi_of(logic [1:0] m, int n);
    return m[1] ? eff(n) - 1 : (eff(n) + 1) / 2;
  endfunction
  function automatic int lo_of(logic [1:0] m, int n);
    return m[1] ? 1 : eff(n) / 2;
  endfunction
  // expected level after k ticks since start
  function automatic bit exp_lvl(logic [1:0] m, int n, int k);
    int t = hi_of(m, n) + lo_of(m, n);
    int p;
    if (m[0]) p = k % t;
    else begin
      if (k >= t) return 1'b1;
      p = k;
    end
    return (p < hi_of(m, n));
  endfunction

  task automatic chk(bit got, bit exp, string req, int k);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s tick=%0d got=%0b exp=%0b", req, k, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step(int gap);
    for (int i = 0; i < gap; i++) @(negedge clk);
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic load(logic [1:0] m, int n);
    wr(2'b10, 8'(n));
    wr(2'b11, {m, 6'(n >> 8)});
  endtask

  task automatic run_seq(logic [1:0] m, int n, int ticks, bit rnd_gap, string req);
    load(m, n);
    wr(2'b00, 8'hC0);
    chk(tmr, 1'b1, req, 0);
    for (int k = 1; k <= ticks; k++) begin
      step(rnd_gap ? int'($urandom_range(0, 2)) : 0);
      chk(tmr, exp_lvl(m, n, k), req, k);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(tmr, 1'b1, "R1 in reset", 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tmr, 1'b1, "R1 after reset", 0);

    // R2: load without start
    load(2'b01, 197);
    for (int k = 1; k <= 10; k++) begin
      step(0);
      chk(tmr, 1'b1, "R2 no start", k);
    end

    // R3 R4: 197 continuous -> 99 high, 98 low
    run_seq(2'b01, 197, 2 * 197 + 2, 1'b0, "R4 197 split");
    run_seq(2'b00, 10, 14, 1'b0, "R6 single square");
    run_seq(2'b00, 7, 10, 1'b0, "R4 odd single");
    run_seq(2'b10, 5, 9, 1'b0, "R7 single pulse");
    run_seq(2'b11, 4, 13, 1'b0, "R8 repeat pulse");
    run_seq(2'b01, 0, 6, 1'b0, "R10 count 0");
    run_seq(2'b01, 1, 6, 1'b0, "R10 count 1");
    run_seq(2'b01, 9, 30, 1'b1, "R11 gapped ticks");

    // R5: reload uses count rewritten during low phase
    run_seq(2'b01, 6, 4, 1'b0, "R5 first period");
    wr(2'b10, 8'd4);
    for (int k = 5; k <= 6; k++) begin
      step(0);
      chk(tmr, exp_lvl(2'b01, 6, k), "R5 first period", k);
    end
    for (int k = 1; k <= 9; k++) begin
      step(0);
      chk(tmr, exp_lvl(2'b01, 4, k), "R5 reloaded period", k);
    end

    // R9: stop while low
    run_seq(2'b01, 10, 6, 1'b0, "R9 pre-stop");
    wr(2'b00, 8'h40);
    chk(tmr, 1'b1, "R9 stop", 0);
    for (int k = 1; k <= 20; k++) begin
      step(0);
      chk(tmr, 1'b1, "R9 stopped", k);
    end
    // R3: restart from stopped, and restart while running
    run_seq(2'b01, 10, 7, 1'b0, "R3 restart");
    run_seq(2'b01, 8, 20, 1'b0, "R3 restart running");

    // R12: ignored writes mid-run
    run_seq(2'b01, 8, 5, 1'b0, "R12 pre");
    wr(2'b01, 8'hC0);
    wr(2'b00, 8'h00);
    wr(2'b00, 8'h80);
    chk(tmr, exp_lvl(2'b01, 8, 5), "R12 after writes", 5);
    for (int k = 6; k <= 30; k++) begin
      step(0);
      chk(tmr, exp_lvl(2'b01, 8, k), "R12 continue", k);
    end

    // random mix
    for (int s = 0; s < 25; s++) begin
      logic [1:0] m = 2'($urandom_range(0, 3));
      int n = int'($urandom_range(0, 260));
      int t = hi_of(m, n) + lo_of(m, n);
      run_seq(m, n, 2 * t + 3, 1'b1, "R4 R5 R6 R7 R8 random");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule